// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This block takes a mantissa whose two lowest bits are the guard and round positions, together with a separate sticky input, the operand sign and a two-bit direction select. It decides whether the retained fraction must be bumped by one unit in the last place. It returns the fraction with guard and round dropped, incremented where the direction requires, plus a set of one-cycle status flags. These flags are inexact, fraction-inexact and fraction-rounded, and there is also a rounded-up indication.

The unit is one registered stage. A result appears one clock after `in_valid` and is marked by `out_valid`. The increment carries through every fraction bit. When every retained bit is one and an increment happens, the carry lands in an extra top output bit that stands for the value 2.0. The downstream consumer renormalises that case and adjusts the exponent. It also makes every overflow decision. The incrementer can be built either as one wide adder or as a segmented carry-select chain, and a parameter picks which.

Top module: `mant_round_unit`

## Requirements
- R1: `out_mant` equals `in_mant` shifted right by two bits, with bit 0 of `in_mant` as round and bit 1 as guard, plus one when an increment is chosen; its top bit is the carry position above the retained fraction.
- R2: When guard, round and sticky are all zero, the fraction passes unchanged and `out_inexact`, `out_frac_inexact`, `out_frac_rounded` and `out_rnd_up` stay low.
- R3: When any of guard, round or sticky is set, `out_inexact` and `out_frac_inexact` are both high for that result.
- R4: In nearest mode (`in_mode` = 2'b00), no increment happens while guard is clear.
- R5: In nearest mode with guard set and either round or sticky set, the fraction is incremented.
- R6: In nearest mode with guard set and round and sticky clear (a tie), the fraction is incremented only if its least significant retained bit is one, so ties go to even.
- R7: In toward-zero mode (`in_mode` = 2'b01), the fraction is never incremented.
- R8: In toward-plus-infinity mode (`in_mode` = 2'b10), an inexact result is incremented only when `in_sign` is 0.
- R9: In toward-minus-infinity mode (`in_mode` = 2'b11), an inexact result is incremented only when `in_sign` is 1.
- R10: Every increment raises both `out_frac_rounded` and `out_rnd_up`; with no increment both stay low.
- R11: The increment carry ripples through the whole fraction, including across internal segment borders, and an all-ones fraction becomes the value with only the top carry bit set.
- R12: `out_valid` is `in_valid` delayed by one clock, and all flags are low whenever `out_valid` is low.
- R13: While `rst_n` is low at a clock edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 2 | Direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_mant | input | MANT_W | Mantissa; bit 1 guard, bit 0 round |
| in_sticky | input | 1 | OR of all bits below the round position |
| out_valid | output | 1 | Result present |
| out_mant | output | MANT_W-1 | Rounded fraction with carry bit on top |
| out_rnd_up | output | 1 | Result was incremented |
| out_inexact | output | 1 | Inexact flag pulse |
| out_frac_inexact | output | 1 | Fraction-inexact flag pulse |
| out_frac_rounded | output | 1 | Fraction-rounded flag pulse |

## Verification
A wrong direction decision shows at the ports one cycle after the operand. `out_mant` is then off by exactly one unit, and `out_rnd_up` and `out_frac_rounded` disagree with the mode, sign and low bits that were applied. A broken carry segment shows in that same cycle, but only for fractions whose low segments are all ones. That is why the directed cases place a run of ones right up to a segment border and also across the full width. A stuck flag or valid register shows on the first idle cycle, when a flag stays high while `out_valid` is low.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

   // Direction select; encoding is part of the block's interface.
   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_POS_INF = 2'b10,
      RM_NEG_INF = 2'b11
   } rnd_mode_e;

   // Incrementer variants.
   localparam int unsigned INC_FLAT   = 0;
   localparam int unsigned INC_CSEL   = 1;

   // Low-bit bundle seen by the decision logic.
   typedef struct packed {
      logic guard;
      logic round;
      logic sticky;
      logic lsb;
   } low_bits_t;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
   import mant_round_pkg::*;
(
   input  rnd_mode_e mode_i,
   input  logic      sign_i,
   input  low_bits_t low_i,
   output logic      inexact_o,
   output logic      inc_o
);

   logic lost_c;
   logic near_c;

   assign lost_c = low_i.guard | low_i.round | low_i.sticky;

   // Nearest: bump only past half, or exactly half with odd lsb.
   assign near_c = low_i.guard & (low_i.round | low_i.sticky | low_i.lsb);

   always_comb begin
      inc_o = 1'b0;
      if (lost_c) begin
         unique case (mode_i)
            RM_NEAREST: inc_o = near_c;
            RM_ZERO:    inc_o = 1'b0;
            RM_POS_INF: inc_o = ~sign_i;
            RM_NEG_INF: inc_o = sign_i;
            default:    inc_o = 1'b0;
         endcase
      end
   end

   assign inexact_o = lost_c;

   // R10: an increment is only ever taken for an inexact operand
   always_comb begin
      if (inc_o === 1'b1) begin
         inc_needs_loss_chk: assert (lost_c === 1'b1)
            else $error("increment without lost bits");
      end
   end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr
   import mant_round_pkg::*;
#(
   parameter int unsigned W     = 55,
   parameter int unsigned STYLE = INC_CSEL,
   parameter int unsigned SEG_W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic         inc_i,
   output logic [W-1:0] sum_o
);

   localparam int unsigned NSEG  = (W + SEG_W - 1) / SEG_W;
   localparam int unsigned PAD_W = NSEG * SEG_W;

   generate
      if (W < 2) begin : g_bad_w
         $error("rnd_incr: W must be at least 2");
      end
      if (SEG_W < 1) begin : g_bad_seg
         $error("rnd_incr: SEG_W must be at least 1");
      end
      if (STYLE > INC_CSEL) begin : g_bad_style
         $error("rnd_incr: unknown STYLE");
      end

      if (STYLE == INC_FLAT) begin : g_flat
         assign sum_o = a_i + {{(W-1){1'b0}}, inc_i};
      end else begin : g_csel
         logic [PAD_W-1:0] a_pad;
         logic [PAD_W-1:0] s_pad;
         logic [NSEG:0]    cy;

         assign a_pad = PAD_W'(a_i);
         assign cy[0] = inc_i;

         for (genvar g = 0; g < NSEG; g++) begin : g_seg
            logic [SEG_W-1:0] seg_c;
            logic [SEG_W-1:0] seg_p1_c;
            assign seg_c    = a_pad[g*SEG_W +: SEG_W];
            assign seg_p1_c = seg_c + SEG_W'(1);
            assign s_pad[g*SEG_W +: SEG_W] = cy[g] ? seg_p1_c : seg_c;
            assign cy[g+1]  = cy[g] & (&seg_c);
         end

         assign sum_o = s_pad[W-1:0];

         // R11: the chain never carries beyond the padded width when the
         // top operand bit is clear, and padding bits stay zero
         always_comb begin
            if (inc_i === 1'b1 && a_i[W-1] === 1'b0) begin
               no_chain_escape_chk: assert (cy[NSEG] == 1'b0)
                  else $error("carry left the segment chain");
               pad_zero_chk: assert ((s_pad >> W) == '0)
                  else $error("padding bits of the sum are set");
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
   import mant_round_pkg::*;
#(
   parameter int unsigned MANT_W    = 56,
   parameter int unsigned INC_STYLE = INC_CSEL,
   parameter int unsigned SEG_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_mode,
   input  logic              in_sign,
   input  logic [MANT_W-1:0] in_mant,
   input  logic              in_sticky,
   output logic              out_valid,
   output logic [MANT_W-2:0] out_mant,
   output logic              out_rnd_up,
   output logic              out_inexact,
   output logic              out_frac_inexact,
   output logic              out_frac_rounded
);

   localparam int unsigned FRAC_W = MANT_W - 2;
   localparam int unsigned RES_W  = FRAC_W + 1;

   generate
      if (MANT_W < 4) begin : g_bad_mant
         $error("mant_round_unit: MANT_W must be at least 4");
      end
   endgenerate

   logic [FRAC_W-1:0] frac_c;
   low_bits_t         low_c;
   logic              inexact_c;
   logic              inc_c;
   logic [RES_W-1:0]  sum_c;

   assign frac_c       = in_mant[MANT_W-1:2];
   assign low_c.guard  = in_mant[1];
   assign low_c.round  = in_mant[0];
   assign low_c.sticky = in_sticky;
   assign low_c.lsb    = in_mant[2];

   rnd_decide u_dec (
      .mode_i    (rnd_mode_e'(in_mode)),
      .sign_i    (in_sign),
      .low_i     (low_c),
      .inexact_o (inexact_c),
      .inc_o     (inc_c)
   );

   rnd_incr #(
      .W     (RES_W),
      .STYLE (INC_STYLE),
      .SEG_W (SEG_W)
   ) u_inc (
      .a_i   ({1'b0, frac_c}),
      .inc_i (inc_c),
      .sum_o (sum_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid        <= 1'b0;
         out_mant         <= '0;
         out_rnd_up       <= 1'b0;
         out_inexact      <= 1'b0;
         out_frac_inexact <= 1'b0;
         out_frac_rounded <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mant         <= sum_c;
            out_rnd_up       <= inc_c;
            out_inexact      <= inexact_c;
            out_frac_inexact <= inexact_c;
            out_frac_rounded <= inc_c;
         end else begin
            out_rnd_up       <= 1'b0;
            out_inexact      <= 1'b0;
            out_frac_inexact <= 1'b0;
            out_frac_rounded <= 1'b0;
         end
      end
   end

   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R12
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R12
   quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_rnd_up | out_inexact | out_frac_inexact | out_frac_rounded));

   // R7
   zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'b01) |=> !out_rnd_up);

   // R2
   exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=>
         (!out_inexact && !out_rnd_up && out_mant == {1'b0, $past(in_mant[MANT_W-1:2])}));

   // R10
   up_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_rnd_up |-> (out_frac_rounded && out_inexact));

   // R3
   fi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_inexact == out_frac_inexact));

endmodule

// File: tb/tb_mant_round_unit.sv
module tb_mant_round_unit;

   localparam int MW = 56;
   localparam int FW = MW - 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_mode = 2'b00;
   logic          in_sign = 1'b0;
   logic [MW-1:0] in_mant = '0;
   logic          in_sticky = 1'b0;
   logic          out_valid;
   logic [MW-2:0] out_mant;
   logic          out_rnd_up, out_inexact, out_frac_inexact, out_frac_rounded;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mant_round_unit #(.MANT_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_sign(in_sign), .in_mant(in_mant), .in_sticky(in_sticky),
      .out_valid(out_valid), .out_mant(out_mant), .out_rnd_up(out_rnd_up),
      .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
      .out_frac_rounded(out_frac_rounded)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operand at a falling edge, sample one clock later.
   task automatic apply(input logic [1:0] mode, input logic sgn,
                        input logic [FW-1:0] frac, input logic [1:0] gr,
                        input logic st);
      @(negedge clk);
      in_valid  = 1'b1;
      in_mode   = mode;
      in_sign   = sgn;
      in_mant   = {frac, gr};
      in_sticky = st;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic [MW-2:0] mant,
                             input logic up, input logic inx);
      chk({req, " valid"}, 64'(out_valid), 64'd1);
      chk({req, " mant"}, 64'(out_mant), 64'(mant));
      chk({req, " rnd_up"}, 64'(out_rnd_up), 64'(up));
      chk({req, " frac_rounded"}, 64'(out_frac_rounded), 64'(up));
      chk({req, " inexact"}, 64'(out_inexact), 64'(inx));
      chk({req, " frac_inexact"}, 64'(out_frac_inexact), 64'(inx));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R13 valid", 64'(out_valid), 64'd0);
      chk("R13 mant", 64'(out_mant), 64'd0);
      chk("R13 flags", 64'({out_rnd_up, out_inexact, out_frac_inexact, out_frac_rounded}), 64'd0);
   endtask

   task automatic t_exact;
      apply(2'b00, 1'b0, 54'h12_3456_789A_BCDE, 2'b00, 1'b0);
      expect_res("R2 R1 exact nearest", 55'h12_3456_789A_BCDE, 1'b0, 1'b0);
      apply(2'b10, 1'b0, 54'h00_0000_0000_0007, 2'b00, 1'b0);
      expect_res("R2 exact plus-inf", 55'h7, 1'b0, 1'b0);
   endtask

   task automatic t_nearest;
      // R4: guard clear, round and sticky set
      apply(2'b00, 1'b0, 54'h10, 2'b01, 1'b1);
      expect_res("R4 R3 below half", 55'h10, 1'b0, 1'b1);
      // R5: guard and round set
      apply(2'b00, 1'b0, 54'h10, 2'b11, 1'b0);
      expect_res("R5 above half round", 55'h11, 1'b1, 1'b1);
      // R5: guard and sticky set
      apply(2'b00, 1'b1, 54'h10, 2'b10, 1'b1);
      expect_res("R5 above half sticky", 55'h11, 1'b1, 1'b1);
      // R6: ties
      apply(2'b00, 1'b0, 54'h10, 2'b10, 1'b0);
      expect_res("R6 tie even", 55'h10, 1'b0, 1'b1);
      apply(2'b00, 1'b0, 54'h11, 2'b10, 1'b0);
      expect_res("R6 tie odd", 55'h12, 1'b1, 1'b1);
   endtask

   task automatic t_zero;
      apply(2'b01, 1'b0, 54'h21, 2'b11, 1'b1);
      expect_res("R7 zero pos", 55'h21, 1'b0, 1'b1);
      apply(2'b01, 1'b1, 54'h21, 2'b10, 1'b0);
      expect_res("R7 zero neg", 55'h21, 1'b0, 1'b1);
   endtask

   task automatic t_directed;
      apply(2'b10, 1'b0, 54'h40, 2'b00, 1'b1);
      expect_res("R8 plus-inf pos", 55'h41, 1'b1, 1'b1);
      apply(2'b10, 1'b1, 54'h40, 2'b01, 1'b0);
      expect_res("R8 plus-inf neg", 55'h40, 1'b0, 1'b1);
      apply(2'b11, 1'b1, 54'h40, 2'b01, 1'b0);
      expect_res("R9 minus-inf neg", 55'h41, 1'b1, 1'b1);
      apply(2'b11, 1'b0, 54'h40, 2'b11, 1'b1);
      expect_res("R9 minus-inf pos", 55'h40, 1'b0, 1'b1);
   endtask

   task automatic t_carry;
      apply(2'b00, 1'b0, 54'hFF, 2'b11, 1'b0);
      expect_res("R11 segment border", 55'h100, 1'b1, 1'b1);
      apply(2'b10, 1'b0, 54'h00_0000_FFFF_FFFF, 2'b00, 1'b1);
      expect_res("R11 multi segment", 55'h00_0001_0000_0000, 1'b1, 1'b1);
      apply(2'b00, 1'b0, {FW{1'b1}}, 2'b10, 1'b1);
      expect_res("R11 R10 to two", 55'h40_0000_0000_0000, 1'b1, 1'b1);
   endtask

   task automatic t_idle;
      apply(2'b00, 1'b0, 54'h3, 2'b11, 1'b1);
      expect_res("R12 before idle", 55'h4, 1'b1, 1'b1);
      @(negedge clk);
      chk("R12 idle valid", 64'(out_valid), 64'd0);
      chk("R12 idle flags", 64'({out_rnd_up, out_inexact, out_frac_inexact, out_frac_rounded}), 64'd0);
   endtask

   task automatic t_reset_mid;
      apply(2'b00, 1'b0, 54'h5, 2'b11, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R13 mid reset valid", 64'(out_valid), 64'd0);
      chk("R13 mid reset mant", 64'(out_mant), 64'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_exact();
      t_nearest();
      t_zero();
      t_directed();
      t_carry();
      t_idle();
      t_reset_mid();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule